// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up one translation in a hashed page table. A lookup request carries a virtual page number, which is the virtual address shifted right by 12 bits. It also carries a page-size shift and a flag that chooses between 256 MB and 1 TB segments. The block folds the segment identifier against the page index inside the segment to get a 39-bit hash. It masks the hash with a table-size mask to choose a group of eight entries. It then reads those entries one per cycle from a synchronous entry memory that sits outside the block.

Each entry has two 64-bit doublewords. The block compares the first doubleword of each entry against a tag built from the request. The first entry that matches, scanning slots in ascending order, ends the search. The block then reports the entry address and the entry's second doubleword. If the caller enables it, a second pass searches the group chosen by the complemented hash, and only entries that carry the secondary flag can hit there. A start pulse begins a lookup, and a one-cycle done pulse ends it with either hit or miss set.

Top module: `hpt_group_search`

## Requirements
- R1: With `seg_large`=0, the hash is (vpn >> 16) XOR ((vpn & 0xFFFF) >> (page_shift − 12)), masked to its low 39 bits.
- R2: With `seg_large`=1, let s = vpn >> 28. The hash is s XOR (s << 25) XOR ((vpn & 0xFFFFFFF) >> (page_shift − 12)), masked to its low 39 bits.
- R3: The group is (hash AND table_mask). Entry addresses are {group, slot}, with slot being the low 3 bits. Reads go out one per cycle in slot order 0 to 7, starting at slot 0, and only while the block is busy.
- R4: The expected tag has the segment-size code (0 = 256 MB, 1 = 1 TB) in bits 63:62 and vpn >> 11 in bits 61:7. A match needs equal bits 63:7. Bits 6:0 of the entry play no part in the tag compare.
- R5: An entry whose bit 0 (valid) is 0 never hits.
- R6: An entry's bit 1 (secondary) must be 0 to hit on the primary pass and 1 to hit on the secondary pass.
- R7: The lowest matching slot wins. `hit_index` is its entry address and `hit_dw1` is its second doubleword.
- R8: If `sec_en` is 1 and the primary group has no hit, a second pass searches group (~hash AND table_mask). If `sec_en` is 0, no second pass runs.
- R9: When no searched slot hits, the block raises `done` with `miss`=1 and `hit`=0.
- R10: `done` rises N cycles after the clock edge that accepts `start`, where N depends on the outcome:
  - a primary hit in slot k gives N = 4+k;
  - a primary-only miss gives N = 11;
  - a secondary hit in slot k gives N = 13+k;
  - a secondary miss gives N = 20.
- R11: While `busy` is 1, `start` and changes on the request inputs are ignored.
- R12: After reset, `busy`, `done` and `mem_rd_en` are 0. `done` lasts one cycle, with exactly one of `hit` or `miss` set, and `busy` falls on the same edge that raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (taken only while idle) |
| vpn | input | 64 | Virtual page number (address >> 12) |
| page_shift | input | 6 | Base page-size shift, 12 or more |
| seg_large | input | 1 | 1 = 1 TB segment, 0 = 256 MB segment |
| sec_en | input | 1 | Allow the secondary-group pass |
| table_mask | input | GRP_W | Group-number mask selecting table size |
| mem_rd_en | output | 1 | Entry memory read strobe |
| mem_rd_addr | output | GRP_W+3 | Entry address {group, slot} |
| mem_dw0 | input | 64 | First doubleword, one cycle after the read |
| mem_dw1 | input | 64 | Second doubleword, one cycle after the read |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Lookup found an entry |
| miss | output | 1 | Lookup found nothing |
| hit_index | output | GRP_W+3 | Entry address of the hit |
| hit_dw1 | output | 64 | Second doubleword of the hit |

## Verification
The bound checker watches the read stream and the handshake on every cycle. It checks that reads only happen while busy, that each pass starts at slot 0 and steps up by one slot per cycle, that done is a single-cycle pulse with exactly one of hit or miss set, and that an accepted start makes the block busy. The hash folds, the tag and flag rules, first-match priority, the secondary pass and the exact done cycle can only be shown by the bench's scenarios. For these, the bench's reference model places entries in chosen groups, including near-miss entries that differ in one flag or one tag bit, and predicts the outcome and its timing.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
    localparam int VPN_W       = 64;
    localparam int DW_W        = 64;
    localparam int HASH_W      = 39;
    localparam int SLOTS       = 8;
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int SMALL_IDX_W = 16;   // 28-bit segment offset minus 12
    localparam int LARGE_IDX_W = 28;   // 40-bit segment offset minus 12
    localparam int LARGE_FOLD  = 25;
    localparam int PN_DROP     = 11;   // 23 address bits minus 12
    localparam int TAG_LSB     = 7;
    localparam logic [5:0] BASE_SHIFT = 6'd12;
    localparam logic [DW_W-1:0] TAG_CMP_MASK = ~((DW_W'(1) << TAG_LSB) - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HASH,
        ST_BASE,
        ST_SCAN
    } scan_state_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [5:0]       pshift;
        logic             seg_large;
    } lookup_req_t;

    function automatic logic [HASH_W-1:0] page_hash(input lookup_req_t r);
        logic [5:0]       drop;
        logic [VPN_W-1:0] sid;
        logic [VPN_W-1:0] pidx;
        logic [VPN_W-1:0] h;
        drop = r.pshift - BASE_SHIFT;
        if (r.seg_large) begin
            sid  = r.vpn >> LARGE_IDX_W;
            pidx = r.vpn & ((VPN_W'(1) << LARGE_IDX_W) - 1);
            h    = sid ^ (sid << LARGE_FOLD) ^ (pidx >> drop);
        end else begin
            sid  = r.vpn >> SMALL_IDX_W;
            pidx = r.vpn & ((VPN_W'(1) << SMALL_IDX_W) - 1);
            h    = sid ^ (pidx >> drop);
        end
        return HASH_W'(h);
    endfunction

    function automatic logic [DW_W-1:0] expect_tag(input lookup_req_t r);
        logic [DW_W-1:0] t;
        t = '0;
        t[DW_W-1:DW_W-2] = {1'b0, r.seg_large};
        t[DW_W-3:TAG_LSB] = (DW_W-2-TAG_LSB)'(r.vpn >> PN_DROP);
        return t;
    endfunction

    function automatic logic slot_hit(input logic [DW_W-1:0] dw0,
                                      input logic [DW_W-1:0] tag,
                                      input logic            sec_pass);
        return dw0[0] && (dw0[1] == sec_pass) && (((dw0 ^ tag) & TAG_CMP_MASK) == '0);
    endfunction
endpackage

// File: rtl/hpt_hash_stage.sv
`timescale 1ns/1ps
module hpt_hash_stage
    import hpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  lookup_req_t       req_in,
    output logic [HASH_W-1:0] hash_q,
    output logic [DW_W-1:0]   tag_q
);
    lookup_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            hash_q <= '0;
            tag_q  <= '0;
        end else begin
            if (load) req_q <= req_in;
            hash_q <= page_hash(req_q);
            tag_q  <= expect_tag(req_q);
        end
    end
endmodule

// File: rtl/hpt_slot_match.sv
`timescale 1ns/1ps
module hpt_slot_match
    import hpt_pkg::*;
(
    input  logic [DW_W-1:0] dw0,
    input  logic [DW_W-1:0] tag,
    input  logic            sec_pass,
    output logic            match
);
    always_comb match = slot_hit(dw0, tag, sec_pass);
endmodule

// File: rtl/hpt_scan_ctrl.sv
`timescale 1ns/1ps
module hpt_scan_ctrl
    import hpt_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int ADDR_W = GRP_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sec_en,
    input  logic [GRP_W-1:0]  table_mask,
    input  logic [HASH_W-1:0] hash_q,
    input  logic              slot_match,
    input  logic [DW_W-1:0]   mem_dw1,
    output logic              load_req,
    output logic              sec_pass,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              miss,
    output logic [ADDR_W-1:0] hit_index,
    output logic [DW_W-1:0]   hit_dw1
);
    scan_state_e       state;
    logic [GRP_W-1:0]  mask_q;
    logic              sec_en_q;
    logic [GRP_W-1:0]  grp_q;
    logic [SLOT_W:0]   islot;
    logic              chk_v;
    logic [SLOT_W-1:0] chk_slot;
    logic              last_slot;

    always_comb begin
        load_req    = (state == ST_IDLE) && start;
        busy        = (state != ST_IDLE);
        mem_rd_en   = (state == ST_SCAN) && !islot[SLOT_W];
        mem_rd_addr = {grp_q, islot[SLOT_W-1:0]};
        last_slot   = (chk_slot == SLOT_W'(SLOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mask_q    <= '0;
            sec_en_q  <= 1'b0;
            grp_q     <= '0;
            islot     <= '0;
            chk_v     <= 1'b0;
            chk_slot  <= '0;
            sec_pass  <= 1'b0;
            done      <= 1'b0;
            hit       <= 1'b0;
            miss      <= 1'b0;
            hit_index <= '0;
            hit_dw1   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q   <= table_mask;
                        sec_en_q <= sec_en;
                        state    <= ST_HASH;
                    end
                end
                ST_HASH: state <= ST_BASE;
                ST_BASE: begin
                    grp_q    <= GRP_W'(hash_q & HASH_W'(mask_q));
                    sec_pass <= 1'b0;
                    islot    <= '0;
                    chk_v    <= 1'b0;
                    state    <= ST_SCAN;
                end
                ST_SCAN: begin
                    chk_v    <= mem_rd_en;
                    chk_slot <= islot[SLOT_W-1:0];
                    if (mem_rd_en) islot <= islot + 1'b1;
                    if (chk_v && slot_match) begin
                        done      <= 1'b1;
                        hit       <= 1'b1;
                        miss      <= 1'b0;
                        hit_index <= {grp_q, chk_slot};
                        hit_dw1   <= mem_dw1;
                        chk_v     <= 1'b0;
                        state     <= ST_IDLE;
                    end else if (chk_v && last_slot) begin
                        chk_v <= 1'b0;
                        if (!sec_pass && sec_en_q) begin
                            sec_pass <= 1'b1;
                            grp_q    <= GRP_W'(~hash_q & HASH_W'(mask_q));
                            islot    <= '0;
                        end else begin
                            done  <= 1'b1;
                            hit   <= 1'b0;
                            miss  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpt_group_search.sv
`timescale 1ns/1ps
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int ADDR_W = GRP_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [5:0]        page_shift,
    input  logic              seg_large,
    input  logic              sec_en,
    input  logic [GRP_W-1:0]  table_mask,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DW_W-1:0]   mem_dw0,
    input  logic [DW_W-1:0]   mem_dw1,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              miss,
    output logic [ADDR_W-1:0] hit_index,
    output logic [DW_W-1:0]   hit_dw1
);
    lookup_req_t       req_in;
    logic [HASH_W-1:0] hash_q;
    logic [DW_W-1:0]   tag_q;
    logic              load_req;
    logic              sec_pass;
    logic              slot_match;

    always_comb begin
        req_in.vpn       = vpn;
        req_in.pshift    = page_shift;
        req_in.seg_large = seg_large;
    end

    hpt_hash_stage u_hash (
        .clk    (clk),
        .rst    (rst),
        .load   (load_req),
        .req_in (req_in),
        .hash_q (hash_q),
        .tag_q  (tag_q)
    );

    hpt_slot_match u_match (
        .dw0      (mem_dw0),
        .tag      (tag_q),
        .sec_pass (sec_pass),
        .match    (slot_match)
    );

    hpt_scan_ctrl #(.GRP_W(GRP_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sec_en      (sec_en),
        .table_mask  (table_mask),
        .hash_q      (hash_q),
        .slot_match  (slot_match),
        .mem_dw1     (mem_dw1),
        .load_req    (load_req),
        .sec_pass    (sec_pass),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .busy        (busy),
        .done        (done),
        .hit         (hit),
        .miss        (miss),
        .hit_index   (hit_index),
        .hit_dw1     (hit_dw1)
    );
endmodule

// File: rtl/hpt_group_search_chk.sv
`timescale 1ns/1ps
module hpt_group_search_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic              miss,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({hit, miss}));

    a_r12_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r3_read_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

    a_r3_pass_starts_slot0: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_en) |-> (mem_rd_addr[2:0] == 3'd0));

    a_r3_slot_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |->
            (mem_rd_addr[2:0] == $past(mem_rd_addr[2:0]) + 3'd1) &&
            (mem_rd_addr[ADDR_W-1:3] == $past(mem_rd_addr[ADDR_W-1:3])));

    a_r11_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind hpt_group_search hpt_group_search_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .hit         (hit),
    .miss        (miss),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/hpt_group_search_tb_top.sv
`timescale 1ns/1ps
module hpt_group_search_tb_top;
    localparam int GRP_W  = 8;
    localparam int ADDR_W = GRP_W + 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [63:0]       vpn = '0;
    logic [5:0]        page_shift = 6'd12;
    logic              seg_large = 1'b0;
    logic              sec_en = 1'b0;
    logic [GRP_W-1:0]  table_mask = '1;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [63:0]       mem_dw0 = '0;
    logic [63:0]       mem_dw1 = '0;
    logic              busy, done, hit, miss;
    logic [ADDR_W-1:0] hit_index;
    logic [63:0]       hit_dw1;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit monitor_on = 0;
    bit finished   = 0;

    // reference model state
    int          exp_done_cyc = -1;
    bit          exp_hit;
    int          exp_idx;
    logic [63:0] exp_dw1;
    string       exp_req;

    logic [63:0] m0 [int];
    logic [63:0] m1 [int];

    always #5 clk = ~clk;

    hpt_group_search #(.GRP_W(GRP_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .vpn(vpn), .page_shift(page_shift),
        .seg_large(seg_large), .sec_en(sec_en), .table_mask(table_mask),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_dw0(mem_dw0), .mem_dw1(mem_dw1), .busy(busy), .done(done),
        .hit(hit), .miss(miss), .hit_index(hit_index), .hit_dw1(hit_dw1)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_dw0 <= m0.exists(int'(mem_rd_addr)) ? m0[int'(mem_rd_addr)] : 64'd0;
            mem_dw1 <= m1.exists(int'(mem_rd_addr)) ? m1[int'(mem_rd_addr)] : 64'd0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [38:0] ref_hash(input logic [63:0] v, input logic [5:0] sh,
                                             input logic big);
        logic [63:0] s, h;
        int d;
        d = int'(sh) - 12;
        if (big) begin
            s = v >> 28;
            h = s ^ (s << 25) ^ ((v & 64'h0FFF_FFFF) >> d);
        end else begin
            h = (v >> 16) ^ ((v & 64'hFFFF) >> d);
        end
        return h[38:0];
    endfunction

    function automatic logic [63:0] ref_tag(input logic [63:0] v, input logic big);
        logic [63:0] t;
        t = (v >> 11) << 7;
        t[63:62] = big ? 2'b01 : 2'b00;
        return t;
    endfunction

    function automatic int ref_group(input logic [63:0] v, input logic [5:0] sh,
                                     input logic big, input logic [7:0] mask, input bit sec);
        logic [38:0] h;
        h = ref_hash(v, sh, big);
        if (sec) h = ~h;
        return int'(h[7:0] & mask);
    endfunction

    task automatic ref_search(input logic [63:0] v, input logic [5:0] sh, input logic big,
                              input logic sec, input logic [7:0] mask,
                              output bit h, output int idx, output logic [63:0] d1,
                              output int lat);
        logic [63:0] tag, d0;
        bit found;
        int e;
        tag = ref_tag(v, big);
        found = 0; h = 0; idx = 0; d1 = '0;
        lat = sec ? 20 : 11;
        for (int p = 0; p < 2; p++) begin
            if (!found && (p == 0 || sec)) begin
                for (int s = 0; s < 8; s++) begin
                    if (!found) begin
                        e  = ref_group(v, sh, big, mask, p != 0) * 8 + s;
                        d0 = m0.exists(e) ? m0[e] : 64'd0;
                        if (d0[0] && (d0[1] == (p != 0)) && (d0[63:7] == tag[63:7])) begin
                            found = 1; h = 1; idx = e;
                            d1  = m1.exists(e) ? m1[e] : 64'd0;
                            lat = (p == 0) ? 4 + s : 13 + s;
                        end
                    end
                end
            end
        end
    endtask

    task automatic place(input logic [63:0] v, input logic [5:0] sh, input logic big,
                         input logic [7:0] mask, input bit sec, input int slot,
                         input logic [63:0] d0, input logic [63:0] d1);
        int e;
        e = ref_group(v, sh, big, mask, sec) * 8 + slot;
        m0[e] = d0;
        m1[e] = d1;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            chk(done == (cyc == exp_done_cyc), exp_req, "done timing (R10)", 64'(done),
                64'(cyc == exp_done_cyc));
            if (cyc == exp_done_cyc && done) begin
                chk(hit == exp_hit, exp_req, "hit", 64'(hit), 64'(exp_hit));
                chk(miss == !exp_hit, exp_req, "miss (R9)", 64'(miss), 64'(!exp_hit));
                chk(!busy, "R12", "busy at done", 64'(busy), 64'd0);
                if (exp_hit) begin
                    chk(int'(hit_index) == exp_idx, exp_req, "hit_index (R3 R7)",
                        64'(hit_index), 64'(exp_idx));
                    chk(hit_dw1 == exp_dw1, exp_req, "hit_dw1 (R7)", hit_dw1, exp_dw1);
                end
            end
        end
    end

    task automatic run_lookup(input logic [63:0] v, input logic [5:0] sh, input logic big,
                              input logic sec, input logic [7:0] mask, input string req,
                              input bit poke_busy);
        bit h; int idx; logic [63:0] d1; int lat;
        ref_search(v, sh, big, sec, mask, h, idx, d1, lat);
        @(negedge clk);
        exp_hit = h; exp_idx = idx; exp_dw1 = d1; exp_req = req;
        vpn = v; page_shift = sh; seg_large = big; sec_en = sec; table_mask = mask;
        start = 1'b1;
        exp_done_cyc = cyc + 1 + lat;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R11: a second start with different inputs while busy must not disturb the lookup
            @(negedge clk);
            vpn = ~v; seg_large = ~big; table_mask = ~mask; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc < exp_done_cyc) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] va, vb, vc, vd, ve, vf, vg, vh;
        logic [63:0] t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R12", "busy after reset", 64'(busy), 64'd0);
        chk(!done, "R12", "done after reset", 64'(done), 64'd0);
        chk(!mem_rd_en, "R12", "mem_rd_en after reset", 64'(mem_rd_en), 64'd0);
        monitor_on = 1;

        // R1 R4: 256 MB, 4 KB page, hit in slot 0
        va = 64'h0000_0123_4567_89AB;
        t = ref_tag(va, 1'b0);
        place(va, 6'd12, 1'b0, 8'hFF, 0, 0, t | 64'h1, 64'hAAAA_0000_1111_2222);
        run_lookup(va, 6'd12, 1'b0, 1'b0, 8'hFF, "R1", 0);

        // R5 R6 R4 R7: near misses before the hit, first of two matches wins
        vb = 64'h0000_0007_9BCD_E135;
        t = ref_tag(vb, 1'b0);
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 0, t, 64'h10);                       // R5 not valid
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 1, t | 64'h3, 64'h11);               // R6 secondary set
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 2, (t ^ 64'h80) | 64'h1, 64'h12);    // R4 bit 7 differs
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 3, (t ^ (64'h1 << 62)) | 64'h1, 64'h13); // R4 size code
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 5, t | 64'h7D, 64'h15);              // R4 low flags ignored
        place(vb, 6'd12, 1'b0, 8'hFF, 0, 6, t | 64'h1, 64'h16);               // R7 later match
        run_lookup(vb, 6'd12, 1'b0, 1'b0, 8'hFF, "R7", 0);

        // R2: 1 TB segment, 16 MB base page, hit in slot 2
        vc = 64'h0000_3A5C_1234_5678;
        place(vc, 6'd24, 1'b1, 8'hFF, 0, 2, ref_tag(vc, 1'b1) | 64'h1, 64'hC0DE_0000_0000_0002);
        run_lookup(vc, 6'd24, 1'b1, 1'b0, 8'hFF, "R2", 0);

        // R1: 256 MB with 64 KB page, hit in last slot
        vd = 64'h0000_0000_0ABC_DEF7;
        place(vd, 6'd16, 1'b0, 8'hFF, 0, 7, ref_tag(vd, 1'b0) | 64'h5, 64'hD7D7_D7D7_0000_0007);
        run_lookup(vd, 6'd16, 1'b0, 1'b0, 8'hFF, "R1", 0);

        // R8 R9: primary miss, second pass disabled even though a secondary entry exists
        ve = 64'h0000_0055_5555_0001;
        place(ve, 6'd12, 1'b0, 8'h3F, 1, 0, ref_tag(ve, 1'b0) | 64'h3, 64'hEEEE);
        run_lookup(ve, 6'd12, 1'b0, 1'b0, 8'h3F, "R8", 0);

        // R8 R6: secondary pass hit, slot 1 lacks the secondary flag
        vf = 64'h0000_0099_0011_2233;
        t = ref_tag(vf, 1'b1);
        place(vf, 6'd20, 1'b1, 8'hFF, 1, 1, t | 64'h1, 64'hBAD1);
        place(vf, 6'd20, 1'b1, 8'hFF, 1, 3, t | 64'h3, 64'hF00D_0000_0000_0003);
        run_lookup(vf, 6'd20, 1'b1, 1'b1, 8'hFF, "R8", 0);

        // R9: miss in both passes
        vg = 64'h0000_0F0F_F0F0_1234;
        run_lookup(vg, 6'd12, 1'b0, 1'b1, 8'h0F, "R9", 0);

        // R11: start while busy is ignored
        run_lookup(va, 6'd12, 1'b0, 1'b0, 8'hFF, "R11", 1);
        vh = 64'h0000_0000_0000_0000;
        run_lookup(vh, 6'd12, 1'b0, 1'b1, 8'hFF, "R11", 1);
        repeat (25) @(negedge clk);   // monitor reports any late extra done

        // R10: primary hit in slot 5 after a secondary-capable lookup
        run_lookup(vb, 6'd12, 1'b0, 1'b1, 8'hFF, "R10", 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(500_000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R10): lookup did not complete, actual cycle %0d expected end", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule